// File: doc/BRIEF.md
# Command-FIFO driven SPI engine

This block is an SPI master whose bus activity is scripted by a stream of 32-bit command entries. Entries are written into a small internal command queue and run one at a time, oldest first. An entry either places the two chip-select lines in a requested state and then idles for a given number of SCLK periods, or moves a counted number of bytes out of a transmit word source and/or into a receive word sink, one bit per SCLK period, most significant bit first.

Transmit bytes come from an external word FIFO through a take strobe, four bytes per word, lowest byte first. Received bytes are packed lowest byte first into 32-bit words that are pushed to an external receive FIFO. A global enable gates the start of each entry. SCLK frequency, polarity and phase come from static configuration inputs. Only single-lane SPI is carried out; the lane-mode field of an entry is accepted and ignored.

Entry fields: bits 7:0 immediate, bit 8 data transfer, bit 9 immediate is an exponent, bits 11:10 lane mode, bit 12 lower chip select, bit 13 upper chip select, bit 16 transmit, bit 17 receive.

Top module: `cmd_spi_engine`

## Requirements
- R1: Out of reset `spi_cs_n` is 2'b11, `spi_sclk` equals `cfg_cpol`, `spi_mosi` is 1, `busy` and `rx_push` are 0, `cmd_empty` is 1 and `cmd_full` is 0.
- R2: The command queue holds up to CMD_DEPTH entries; `cmd_full` rises when it holds CMD_DEPTH, a push while full is dropped, and entries run strictly in push order.
- R3: No entry starts while `enable` is low; queued entries start once it is high.
- R4: When an entry starts, `spi_cs_n[0]` becomes the inverse of entry bit 12 and `spi_cs_n[1]` the inverse of bit 13, and they hold until the next entry starts. An entry with bit 8 clear idles for imm SCLK periods with `spi_sclk` at `cfg_cpol`; `busy` stays high for imm*(2<<cfg_div)+1 clock cycles.
- R5: During a data entry consecutive leading SCLK edges within a byte are (2<<cfg_div) clock cycles apart.
- R6: SCLK rests at `cfg_cpol`; with `cfg_cpha`=0 both sides sample on the leading edge, with `cfg_cpha`=1 on the trailing edge; data moves MSB first.
- R7: A data entry moves imm bytes, or 2^imm bytes when bit 9 is set; with bit 16 set it pulses `tx_take` once per four bytes, sends the word's bytes from bits 7:0 upward, and stalls with SCLK at rest while `tx_avail` is low.
- R8: With bit 17 set, received bytes are packed from bits 7:0 upward; a word is pushed on `rx_push` after every fourth byte and after the entry's last byte, unfilled bytes reading 0.
- R9: With bit 16 clear `spi_mosi` stays 1 during the entry; with bit 17 clear nothing is pushed.
- R10: A data entry whose byte count is 0 keeps `busy` high for one cycle and produces no SCLK edge and no `tx_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows queued entries to start |
| cfg_div | input | 3 | SCLK divider exponent; SCLK = clk/(2<<cfg_div) |
| cfg_cpol | input | 1 | SCLK rest level |
| cfg_cpha | input | 1 | Sample on trailing edge when 1 |
| cmd_push | input | 1 | Write `cmd_word` into the command queue |
| cmd_word | input | 32 | Command entry |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | Command queue empty |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_avail | input | 1 | Transmit FIFO holds a word |
| tx_take | output | 1 | Consumes the transmit head word |
| rx_data | output | 32 | Received word |
| rx_push | output | 1 | `rx_data` valid for one cycle |
| busy | output | 1 | An entry is executing |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 2 | Active-low chip selects, [0] lower, [1] upper |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Assertions watch on every cycle that the queue level never exceeds its depth, that chip selects do not move while an entry runs, that SCLK rests during idle entries, that MOSI is steady across each sampling edge, that no entry starts without enable, and that received words are never pushed back to back. The bench sweeps all four clock modes at three divider settings against a behavioural SPI slave, and only those scenarios show byte order, word packing and partial words, the measured SCLK period, exponent byte counts, transmit stalls, idle durations and queue ordering and overflow.

// File: rtl/cmd_spi_engine.sv
module cmd_spi_engine #(
  parameter int CMD_DEPTH = 4,
  parameter int CNT_W     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [2:0]  cfg_div,
  input  logic        cfg_cpol,
  input  logic        cfg_cpha,
  input  logic        cmd_push,
  input  logic [31:0] cmd_word,
  output logic        cmd_full,
  output logic        cmd_empty,
  input  logic [31:0] tx_data,
  input  logic        tx_avail,
  output logic        tx_take,
  output logic [31:0] rx_data,
  output logic        rx_push,
  output logic        busy,
  output logic        spi_sclk,
  output logic [1:0]  spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int AW = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1;

  logic [31:0] mem [CMD_DEPTH];
  logic [AW:0] wp, rp;

  assign cmd_empty = (wp == rp);
  assign cmd_full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

  always_ff @(posedge clk)
    if (cmd_push && !cmd_full) mem[wp[AW-1:0]] <= cmd_word;

  wire         pop  = enable && !busy && !cmd_empty;
  wire  [31:0] head = mem[rp[AW-1:0]];
  wire  [7:0]  imm  = head[7:0];
  wire  [CNT_W-1:0] n_units = (head[8] && head[9]) ? (CNT_W'(1) << imm) : CNT_W'(imm);
  wire         unused_bits = ^{head[31:18], head[15:14], head[11:10]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (cmd_push && !cmd_full) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
    end

  logic             e_data, e_tx, e_rx, need, ph;
  logic [CNT_W-1:0] rem;
  logic [7:0]       cnt, txb, rxb;
  logic [2:0]       bitn;
  logic [1:0]       lane;
  logic [31:0]      txw, rxw;

  wire [7:0]  hm1       = (8'd1 << cfg_div) - 8'd1;
  wire        tick      = busy && !need && (cnt == hm1);
  wire        last_bit  = !e_data || (bitn == 3'd7);
  wire        tx_blocked = e_tx && (lane == 2'd0) && !tx_avail;
  wire [31:0] rx_merged = rxw | (32'(rxb) << {lane, 3'b000});

  assign tx_take  = busy && need && (rem != '0) && e_tx && (lane == 2'd0) && tx_avail;
  assign spi_sclk = (busy && e_data && !need) ? (cfg_cpol ^ ph ^ cfg_cpha) : cfg_cpol;
  assign spi_mosi = (busy && e_tx && !need) ? txb[7] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; spi_cs_n <= 2'b11; need <= 1'b0; ph <= 1'b0;
      e_data <= 1'b0; e_tx <= 1'b0; e_rx <= 1'b0; rem <= '0;
      cnt <= '0; bitn <= '0; lane <= '0; txb <= '0; rxb <= '0;
      txw <= '0; rxw <= '0; rx_push <= 1'b0; rx_data <= '0;
    end else begin
      rx_push <= 1'b0;
      if (pop) begin
        busy     <= 1'b1;
        e_data   <= head[8];
        e_tx     <= head[8] & head[16];
        e_rx     <= head[8] & head[17];
        spi_cs_n <= {~head[13], ~head[12]};
        rem      <= n_units;
        need     <= head[8] || (n_units == '0);
        lane <= '0; rxw <= '0; cnt <= '0; ph <= 1'b0; bitn <= '0;
      end else if (busy) begin
        if (need) begin
          if (rem == '0) busy <= 1'b0;
          else if (!tx_blocked) begin
            need <= 1'b0;
            if (e_tx && lane == 2'd0) begin
              txw <= tx_data;
              txb <= tx_data[7:0];
            end else txb <= txw[{lane, 3'b000} +: 8];
          end
        end else if (tick) begin
          cnt <= '0;
          ph  <= ~ph;
          if (!ph) rxb <= {rxb[6:0], spi_miso};
          else if (last_bit) begin
            rem  <= rem - 1'b1;
            bitn <= '0;
            if (e_data) begin
              need <= 1'b1;
              lane <= lane + 1'b1;
              if (e_rx) begin
                if (lane == 2'd3 || rem == CNT_W'(1)) begin
                  rx_push <= 1'b1;
                  rx_data <= rx_merged;
                  rxw     <= '0;
                end else rxw <= rx_merged;
              end
            end else if (rem == CNT_W'(1)) need <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            txb  <= {txb[6:0], 1'b0};
          end
        end else cnt <= cnt + 1'b1;
      end
    end

  // R2
  fifo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp - rp) <= (AW+1)'(CMD_DEPTH));

  // R3
  start_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable));

  // R4
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));

  // R4
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !e_data) |-> (spi_sclk == cfg_cpol));

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !need && !ph && cnt == hm1) |=> $stable(spi_mosi));

  // R8
  rx_push_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
endmodule

// File: tb/test_cmd_spi_engine.sv
`timescale 1ns/1ps
module test_cmd_spi_engine;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [2:0] cfg_div = 3'd0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic cmd_push = 1'b0;
  logic [31:0] cmd_word = '0;
  logic cmd_full, cmd_empty, tx_take, rx_push, busy, spi_sclk, spi_mosi;
  logic [31:0] tx_data, rx_data;
  logic [1:0] spi_cs_n;
  logic tx_avail = 1'b1, miso = 1'b0;

  always #4 clk = ~clk;

  cmd_spi_engine i_cmd_spi_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cmd_push(cmd_push),
    .cmd_word(cmd_word), .cmd_full(cmd_full), .cmd_empty(cmd_empty),
    .tx_data(tx_data), .tx_avail(tx_avail), .tx_take(tx_take),
    .rx_data(rx_data), .rx_push(rx_push), .busy(busy), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso));

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] txw(int i);
    return 32'h3C5A_9617 ^ (i * 32'h0102_0409);
  endfunction
  function automatic logic [7:0] pat(int k);
    return 8'(k * 37 + 90) ^ 8'hC3;
  endfunction
  function automatic logic bitof(int g);
    logic [7:0] b;
    b = pat(g / 8);
    return b[7 - (g % 8)];
  endfunction
  function automatic logic [31:0] ent(int imm, bit dat, bit ex, bit csl, bit csu, bit tx, bit rx);
    logic [31:0] w;
    w = '0;
    w[7:0] = 8'(imm); w[8] = dat; w[9] = ex; w[11:10] = 2'b01;
    w[12] = csl; w[13] = csu; w[14] = 1'b1; w[16] = tx; w[17] = rx;
    return w;
  endfunction

  int tx_idx = 0, nrx = 0, bcnt = 0;
  logic [31:0] rxq [0:15];
  assign tx_data = txw(tx_idx);
  always @(posedge clk) begin
    if (tx_take) tx_idx <= tx_idx + 1;
    if (busy) bcnt <= bcnt + 1;
    if (rx_push) begin
      if (nrx < 16) rxq[nrx] <= rx_data;
      nrx <= nrx + 1;
    end
  end

  logic [7:0] cap [0:63];
  int gt = 0, gr = 0, nlead = 0, perr = 0;
  longint per = 16;
  time tlast = 0;
  always @(spi_sclk) begin
    if (spi_cs_n[0] == 1'b0) begin
      if (spi_sclk != cfg_cpol) begin
        if ((nlead % 8) != 0 && ($time - tlast) != per) perr++;
        tlast = $time;
        nlead++;
      end
      if ((spi_sclk != cfg_cpol) == !cfg_cpha) begin
        if (gt / 8 < 64) cap[gt / 8][7 - (gt % 8)] = spi_mosi;
        gt++;
      end else if (cfg_cpha) begin
        miso = bitof(gr);
        gr++;
      end else begin
        gr++;
        miso = bitof(gr);
      end
    end
  end

  logic [1:0] cslog [0:15];
  int nl = 0;
  bit logon = 0;
  always @(spi_cs_n) if (logon && nl < 16) begin cslog[nl] = spi_cs_n; nl++; end

  task automatic reset_slave();
    gt = 0; gr = 0; nlead = 0; perr = 0;
    per = longint'(2 << cfg_div) * 8;
    miso = bitof(0);
    for (int i = 0; i < 64; i++) cap[i] = 8'h00;
    @(negedge clk);
    tx_idx = 0; nrx = 0; bcnt = 0;
  endtask

  task automatic push_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_push = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(cmd_empty && !busy));
  endtask

  function automatic int tx_bad(int first, int nb);
    int bad = 0;
    for (int k = 0; k < nb; k++) begin
      logic [31:0] w;
      w = txw(k / 4);
      if (cap[first + k] != w[8*(k%4) +: 8]) bad++;
    end
    return bad;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 2'b11 && spi_sclk == 1'b0 && spi_mosi && !busy && !rx_push
        && cmd_empty && !cmd_full, "R1 reset state",
        {spi_cs_n, spi_sclk, spi_mosi, busy, cmd_empty, cmd_full}, 7'b1101010);
    rst_n = 1'b1;
    reset_slave();

    // R3: held off while disabled
    push_cmd(ent(2, 0, 0, 1, 0, 0, 0));
    repeat (10) @(negedge clk);
    chk(!busy && !cmd_empty && spi_cs_n == 2'b11, "R3 entry waits for enable",
        {busy, cmd_empty, spi_cs_n}, 4'b0011);
    bcnt = 0;
    enable = 1'b1;
    wait_idle();
    chk(spi_cs_n == 2'b10, "R4 lower select asserted", spi_cs_n, 2'b10);
    chk(bcnt == 5, "R4 idle length div0 imm2", bcnt, 5);

    cfg_div = 3'd1;
    @(negedge clk); bcnt = 0;
    push_cmd(ent(3, 0, 0, 0, 1, 0, 0));
    wait_idle();
    chk(spi_cs_n == 2'b01, "R4 upper select only", spi_cs_n, 2'b01);
    chk(bcnt == 13, "R4 idle length div1 imm3", bcnt, 13);
    push_cmd(ent(1, 0, 0, 0, 0, 0, 0));
    wait_idle();
    chk(spi_cs_n == 2'b11, "R4 release entry", spi_cs_n, 2'b11);

    // R2: ordering, full flag, dropped push
    cfg_div = 3'd0;
    enable = 1'b0;
    push_cmd(ent(1, 0, 0, 1, 0, 0, 0));
    push_cmd(ent(1, 0, 0, 0, 1, 0, 0));
    push_cmd(ent(1, 0, 0, 1, 1, 0, 0));
    push_cmd(ent(2, 0, 0, 0, 0, 0, 0));
    chk(cmd_full, "R2 full at depth", cmd_full, 1);
    push_cmd(ent(7, 0, 0, 1, 0, 0, 0));
    nl = 0; logon = 1; bcnt = 0;
    enable = 1'b1;
    wait_idle();
    logon = 0;
    chk(nl == 4 && cslog[0] == 2'b10 && cslog[1] == 2'b01 && cslog[2] == 2'b00
        && cslog[3] == 2'b11, "R2 entries in order", nl, 4);
    chk(bcnt == 14 && spi_cs_n == 2'b11, "R2 push while full dropped", bcnt, 14);

    // R10: zero-length data entry
    push_cmd(ent(1, 0, 0, 1, 0, 0, 0));
    wait_idle();
    reset_slave();
    push_cmd(ent(0, 1, 0, 1, 0, 1, 0));
    wait_idle();
    chk(bcnt == 1 && nlead == 0 && tx_idx == 0, "R10 zero count", {bcnt, nlead, tx_idx}, 1);

    // R7: stall on empty transmit source
    reset_slave();
    tx_avail = 1'b0;
    push_cmd(ent(2, 1, 0, 1, 0, 1, 0));
    repeat (30) @(negedge clk);
    chk(busy && nlead == 0 && spi_sclk == cfg_cpol, "R7 stall while tx empty", nlead, 0);
    tx_avail = 1'b1;
    wait_idle();
    chk(tx_bad(0, 2) == 0 && tx_idx == 1, "R7 bytes after stall", tx_idx, 1);

    // R7: exponent length 2^3
    reset_slave();
    push_cmd(ent(3, 1, 1, 1, 0, 1, 0));
    wait_idle();
    chk(nlead == 64 && tx_idx == 2 && tx_bad(0, 8) == 0 && nrx == 0,
        "R7 exponent count 8 bytes", nlead, 64);
    push_cmd(ent(1, 0, 0, 0, 0, 0, 0));
    wait_idle();

    // Sweep of divider and clock modes
    for (int d = 0; d < 3; d++)
      for (int m = 0; m < 4; m++) begin
        int bad;
        logic [31:0] e0, e1;
        cfg_div = 3'(d); cfg_cpol = m[1]; cfg_cpha = m[0];
        reset_slave();
        push_cmd(ent(1, 0, 0, 1, 0, 0, 0));
        push_cmd(ent(6, 1, 0, 1, 0, 1, 0));
        push_cmd(ent(5, 1, 0, 1, 0, 0, 1));
        push_cmd(ent(1, 0, 0, 0, 0, 0, 0));
        wait_idle();
        chk(tx_bad(0, 6) == 0 && tx_idx == 2, $sformatf("R7 R6 tx bytes div%0d mode%0d", d, m),
            tx_bad(0, 6), 0);
        bad = 0;
        for (int k = 6; k < 11; k++) if (cap[k] != 8'hFF) bad++;
        chk(bad == 0, $sformatf("R9 mosi idle high div%0d mode%0d", d, m), bad, 0);
        e0 = {pat(9), pat(8), pat(7), pat(6)};
        e1 = {24'h0, pat(10)};
        chk(nrx == 2 && rxq[0] == e0 && rxq[1] == e1,
            $sformatf("R8 R6 rx words div%0d mode%0d", d, m), rxq[1], e1);
        chk(perr == 0 && nlead == 88, $sformatf("R5 sclk period div%0d mode%0d", d, m),
            perr, 0);
        chk(spi_sclk == cfg_cpol && spi_cs_n == 2'b11,
            $sformatf("R6 sclk rest div%0d mode%0d", d, m), spi_sclk, cfg_cpol);
      end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule